// File: doc/BRIEF.md
# Refresh-Slot LCD Scanout Controller

This block streams a framebuffer to a row/column-driven graphical LCD that accepts eight pixels per load. It owns no pixel clock. Each time the CPU runs a memory refresh slot, the block places the current framebuffer address on the memory bus, captures the returned byte and pulses the panel's data-load input. Because refresh slots follow instruction fetches, bytes arrive at an irregular rate. The panel only sees loads and row boundaries, so the irregular rate does not matter.

A presettable byte-address counter is used instead of any address arithmetic. Its low seven bits play the role of the refresh count, and upper bits extend it so that a whole frame is covered. A separate counter counts bytes within a row and wraps at 16 (128-pixel rows) or 20 (160-pixel rows). Rows are stored back to back with no padding. At the wrap the block raises a row-load pulse and then holds off the next data load for a few system clocks.

A periodic timer interrupt drives the frame-restart input. A restart presets the address counter to the framebuffer start, clears the row counter and emits the frame signal. If no restart arrives, scanning runs past the end of the frame and sends whatever bytes follow it.

Top module: `lcd_refresh_scan`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mem_addr` equals START_ADDR (default 0xC000), and `lcd_load`, `row_load` and `frame` are low.
- R2: A 0-to-1 change of `rfsh_i` seen at a clock edge produces the following, unless a hold-off or restart applies. In the next cycle `lcd_load` is high for exactly one cycle. `lcd_data` equals `rd_data` as it was at the address presented before the edge. `mem_addr` has advanced by one. A strobe held high for several cycles causes only one transfer.
- R3: Without a restart, `mem_addr` keeps incrementing past START_ADDR+1023 (the end of a 1024-byte frame), and the bytes found there are sent to the panel like any others.
- R4: With `wide_mode`=0 (narrow mode), `row_load` is high in the same cycle as the `lcd_load` of every 16th byte since the last restart, and low with every other load.
- R5: With `wide_mode`=1 (wide mode), `row_load` accompanies every 20th byte instead.
- R6: After a cycle with `row_load` high, `lcd_load` stays low for at least HOLD_CYC cycles (default 2). A strobe edge arriving in that window is deferred until the window ends, not dropped.
- R7: A 0-to-1 change of `frame_restart` causes the following in the next cycle. `frame` is high for exactly one cycle, even if `frame_restart` stays high. `mem_addr` equals START_ADDR. The row byte count restarts at zero.
- R8: When a restart coincides with a strobe edge, or with a deferred transfer, the restart wins. No `lcd_load` is issued, and that byte is not sent afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_i | input | 1 | CPU refresh strobe, active high, synchronous to clk |
| rd_data | input | 8 | Byte read from memory at `mem_addr` |
| frame_restart | input | 1 | Timer-driven frame restart request, rising edge acts |
| wide_mode | input | 1 | 0: 16 bytes per row, 1: 20 bytes per row |
| mem_addr | output | 16 | Framebuffer byte address |
| lcd_data | output | 8 | Eight pixels for the panel |
| lcd_load | output | 1 | One-cycle data-load strobe to the panel |
| row_load | output | 1 | One-cycle row-load pulse at the end of each row |
| frame | output | 1 | One-cycle frame start pulse |

## Verification
Two functions can land on the same clock edge: a frame restart and a byte transfer. The transfer may be a fresh strobe edge or one deferred by the row hold-off. The bench raises the refresh strobe and the restart on the same falling edge. It also fires a restart on the edge where a strobe captured during the hold-off would have been serviced. It then checks that `frame` rises with `mem_addr` at the start address and no load, and that the next ordinary transfer delivers the byte at the start address with the row count begun afresh.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic {
    SCAN_NARROW = 1'b0,
    SCAN_WIDE   = 1'b1
  } scan_mode_e;

  // index of the final byte of a row for the selected mode
  function automatic int unsigned row_last_idx(scan_mode_e mode,
                                               int unsigned narrow_bytes,
                                               int unsigned wide_bytes);
    return (mode == SCAN_WIDE) ? wide_bytes - 1 : narrow_bytes - 1;
  endfunction

endpackage

// File: rtl/lrs_edge.sv
module lrs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/lrs_addr_ctr.sv
module lrs_addr_ctr #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned REF_W      = 7,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - REF_W;

  logic [REF_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             lo_carry;

  // low field mirrors a refresh count; the high field extends it by carry
  always_comb begin
    lo_carry = &lo_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    if (preset_i) begin
      lo_d = START_ADDR[REF_W-1:0];
      hi_d = START_ADDR[ADDR_W-1:REF_W];
    end else if (step_i) begin
      lo_d = lo_q + 1'b1;
      hi_d = hi_q + HI_W'(lo_carry);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= START_ADDR[REF_W-1:0];
      hi_q <= START_ADDR[ADDR_W-1:REF_W];
    end else if (preset_i || step_i) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign addr_o = {hi_q, lo_q};

  // R3: a step without preset always moves forward by exactly one
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !preset_i) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));
endmodule

// File: rtl/lrs_row_pace.sv
module lrs_row_pace
  import lrs_pkg::*;
#(
  parameter int unsigned NARROW_BYTES = 16,
  parameter int unsigned WIDE_BYTES   = 20,
  parameter int unsigned HOLD_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic restart_i,
  input  logic wide_i,
  output logic fire_o,
  output logic row_end_o
);
  localparam int unsigned COL_W  = $clog2(WIDE_BYTES + 1);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 2);
  localparam logic [COL_W-1:0]  N_LAST   =
    COL_W'(row_last_idx(SCAN_NARROW, NARROW_BYTES, WIDE_BYTES));
  localparam logic [COL_W-1:0]  W_LAST   =
    COL_W'(row_last_idx(SCAN_WIDE, NARROW_BYTES, WIDE_BYTES));
  localparam logic [HOLD_W-1:0] HOLD_VAL = HOLD_W'(HOLD_CYC);

  logic [COL_W-1:0]  col_q, col_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              pend_q, pend_d;
  logic              busy, at_last;
  logic [COL_W-1:0]  last_idx;

  assign last_idx = (scan_mode_e'(wide_i) == SCAN_WIDE) ? W_LAST : N_LAST;
  assign at_last  = (col_q >= last_idx);
  assign busy     = (hold_q != '0);
  assign fire_o   = (rise_i | pend_q) & ~busy & ~restart_i;
  assign row_end_o = fire_o & at_last;

  always_comb begin
    col_d  = col_q;
    hold_d = busy ? hold_q - 1'b1 : hold_q;
    pend_d = pend_q;
    if (restart_i) begin
      col_d  = '0;
      hold_d = '0;
      pend_d = 1'b0;
    end else if (fire_o) begin
      col_d  = at_last ? '0 : col_q + 1'b1;
      hold_d = at_last ? HOLD_VAL : '0;
      pend_d = 1'b0;
    end else if (rise_i && busy) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      col_q  <= col_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  // R6: a strobe edge during hold-off is remembered for later
  defer_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && busy && !restart_i) |=> pend_q);
endmodule

// File: rtl/lcd_refresh_scan.sv
module lcd_refresh_scan #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned REF_W        = 7,
  parameter int unsigned NARROW_BYTES = 16,
  parameter int unsigned WIDE_BYTES   = 20,
  parameter int unsigned HOLD_CYC     = 2,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfsh_i,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              frame_restart,
  input  logic              wide_mode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] lcd_data,
  output logic              lcd_load,
  output logic              row_load,
  output logic              frame
);
  logic rfsh_rise, restart_rise;
  logic fire, row_end;
  logic [DATA_W-1:0] data_d;
  logic load_d, row_d, frame_d;

  lrs_edge u_rfsh_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(rfsh_i), .rise_o(rfsh_rise));

  lrs_edge u_restart_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(frame_restart), .rise_o(restart_rise));

  lrs_row_pace #(
    .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES), .HOLD_CYC(HOLD_CYC)
  ) u_pace (
    .clk(clk), .rst_n(rst_n), .rise_i(rfsh_rise), .restart_i(restart_rise),
    .wide_i(wide_mode), .fire_o(fire), .row_end_o(row_end));

  lrs_addr_ctr #(
    .ADDR_W(ADDR_W), .REF_W(REF_W), .START_ADDR(START_ADDR)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .preset_i(restart_rise), .step_i(fire),
    .addr_o(mem_addr));

  always_comb begin
    data_d  = fire ? rd_data : lcd_data;
    load_d  = fire;
    row_d   = row_end;
    frame_d = restart_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcd_data <= '0;
      lcd_load <= 1'b0;
      row_load <= 1'b0;
      frame    <= 1'b0;
    end else begin
      if (fire) lcd_data <= data_d;
      lcd_load <= load_d;
      row_load <= row_d;
      frame    <= frame_d;
    end
  end

  // R2
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_load |=> !lcd_load);
  // R2
  load_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_load |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
  // R4
  row_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |-> lcd_load);
  // R7
  frame_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> (mem_addr == START_ADDR && !lcd_load));
  // R7
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> !frame);

  generate
    if (HOLD_CYC > 0) begin : g_hold_chk
      // R6
      holdoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_load |=> !lcd_load);
    end
  endgenerate
endmodule

// File: tb/lcd_refresh_scan_tb.sv
module lcd_refresh_scan_tb;
  localparam logic [15:0] START = 16'hC000;

  logic clk = 1'b0;
  logic rst_n, rfsh_i, frame_restart, wide_mode;
  logic [7:0]  rd_data, lcd_data;
  logic [15:0] mem_addr;
  logic lcd_load, row_load, frame;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_addr;
  int exp_col;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_of(logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[12:8]};
  endfunction

  assign rd_data = mem_of(mem_addr);

  lcd_refresh_scan u_dut (
    .clk(clk), .rst_n(rst_n), .rfsh_i(rfsh_i), .rd_data(rd_data),
    .frame_restart(frame_restart), .wide_mode(wide_mode),
    .mem_addr(mem_addr), .lcd_data(lcd_data), .lcd_load(lcd_load),
    .row_load(row_load), .frame(frame));

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int last_col();
    return wide_mode ? 19 : 15;
  endfunction

  // one spaced transfer with full checking
  task automatic xfer(input string tag);
    logic [7:0] ed;
    logic       er;
    ed = mem_of(exp_addr);
    er = (exp_col == last_col());
    @(negedge clk) rfsh_i = 1'b1;
    @(negedge clk) rfsh_i = 1'b0;
    chk(lcd_load == 1'b1, {tag, " load"}, 32'(lcd_load), 1);
    chk(lcd_data == ed, {tag, " data"}, 32'(lcd_data), 32'(ed));
    chk(row_load == er, {tag, " row_load"}, 32'(row_load), 32'(er));
    chk(mem_addr == exp_addr + 16'd1, {tag, " addr"}, 32'(mem_addr),
        32'(exp_addr + 16'd1));
    exp_addr = exp_addr + 16'd1;
    exp_col  = er ? 0 : exp_col + 1;
    @(negedge clk);
    chk(lcd_load == 1'b0, {tag, " load pulse"}, 32'(lcd_load), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_restart();
    @(negedge clk) frame_restart = 1'b1;
    @(negedge clk);
    chk(frame == 1'b1, "R7 frame", 32'(frame), 1);
    chk(mem_addr == START, "R7 addr preset", 32'(mem_addr), 32'(START));
    @(negedge clk);
    chk(frame == 1'b0, "R7 frame single", 32'(frame), 0);
    frame_restart = 1'b0;
    exp_addr = START;
    exp_col  = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rfsh_i = 1'b0; frame_restart = 1'b0; wide_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_addr == START, "R1 addr in reset", 32'(mem_addr), 32'(START));
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_addr == START, "R1 addr", 32'(mem_addr), 32'(START));
    chk({lcd_load, row_load, frame} == 3'b000, "R1 strobes",
        32'({lcd_load, row_load, frame}), 0);
    exp_addr = START;
    exp_col  = 0;
  endtask

  task automatic t_narrow_rows();
    wide_mode = 1'b0;
    do_restart();
    for (int i = 0; i < 40; i++) xfer("R4 narrow");
  endtask

  task automatic t_level_hold();
    // R2: strobe held high for 5 cycles gives one transfer only
    logic [15:0] a0;
    a0 = mem_addr;
    @(negedge clk) rfsh_i = 1'b1;
    @(negedge clk);
    chk(lcd_load == 1'b1, "R2 held load", 32'(lcd_load), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(lcd_load == 1'b0, "R2 held single", 32'(lcd_load), 0);
    end
    rfsh_i = 1'b0;
    chk(mem_addr == a0 + 16'd1, "R2 held addr", 32'(mem_addr), 32'(a0 + 16'd1));
    exp_addr = exp_addr + 16'd1;
    exp_col  = (exp_col == last_col()) ? 0 : exp_col + 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_holdoff();
    do_restart();
    for (int i = 0; i < 15; i++) xfer("R6 prep");
    @(negedge clk) rfsh_i = 1'b1;
    @(negedge clk) rfsh_i = 1'b0;
    chk(row_load == 1'b1, "R6 row_load", 32'(row_load), 1);
    exp_addr = exp_addr + 16'd1;
    exp_col  = 0;
    @(negedge clk) rfsh_i = 1'b1;
    chk(lcd_load == 1'b0, "R6 gap1", 32'(lcd_load), 0);
    @(negedge clk) rfsh_i = 1'b0;
    chk(lcd_load == 1'b0, "R6 gap2", 32'(lcd_load), 0);
    @(negedge clk);
    chk(lcd_load == 1'b1, "R6 deferred load", 32'(lcd_load), 1);
    chk(lcd_data == mem_of(exp_addr), "R6 deferred data", 32'(lcd_data),
        32'(mem_of(exp_addr)));
    exp_addr = exp_addr + 16'd1;
    exp_col  = 1;
    repeat (4) @(negedge clk);
    xfer("R6 after");
  endtask

  task automatic t_restart_midrow();
    for (int i = 0; i < 5; i++) xfer("R7 pre");
    do_restart();
    for (int i = 0; i < 17; i++) xfer("R7 row zeroed");
  endtask

  task automatic t_collide();
    do_restart();
    for (int i = 0; i < 3; i++) xfer("R8 pre");
    @(negedge clk) begin rfsh_i = 1'b1; frame_restart = 1'b1; end
    @(negedge clk);
    chk(lcd_load == 1'b0, "R8 no load", 32'(lcd_load), 0);
    chk(frame == 1'b1, "R8 frame", 32'(frame), 1);
    chk(mem_addr == START, "R8 addr", 32'(mem_addr), 32'(START));
    rfsh_i = 1'b0; frame_restart = 1'b0;
    exp_addr = START; exp_col = 0;
    repeat (3) @(negedge clk);
    xfer("R8 first byte");
    // restart on the edge where a deferred transfer would be serviced
    for (int i = 0; i < 14; i++) xfer("R8 prep");
    @(negedge clk) rfsh_i = 1'b1;
    @(negedge clk) rfsh_i = 1'b0;
    @(negedge clk) rfsh_i = 1'b1;
    @(negedge clk) begin rfsh_i = 1'b0; frame_restart = 1'b1; end
    @(negedge clk);
    chk(frame == 1'b1, "R8 frame vs deferred", 32'(frame), 1);
    chk(lcd_load == 1'b0, "R8 deferred dropped", 32'(lcd_load), 0);
    frame_restart = 1'b0;
    @(negedge clk);
    chk(lcd_load == 1'b0, "R8 deferred stays dropped", 32'(lcd_load), 0);
    exp_addr = START; exp_col = 0;
    repeat (3) @(negedge clk);
    xfer("R8 after deferred");
  endtask

  task automatic t_wide();
    wide_mode = 1'b1;
    do_restart();
    for (int i = 0; i < 45; i++) xfer("R5 wide");
    wide_mode = 1'b0;
  endtask

  task automatic t_overrun();
    do_restart();
    for (int i = 0; i < 1030; i++) xfer("R3 overrun");
    chk(mem_addr == START + 16'd1030, "R3 past frame", 32'(mem_addr),
        32'(START + 16'd1030));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    xfer("R2 first");
    t_level_hold();
    t_narrow_rows();
    t_holdoff();
    t_restart_midrow();
    t_collide();
    t_wide();
    t_overrun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule